// File: doc/BRIEF.md
# Move-Only Nybble Processor

This block is a processor with no opcodes. Every instruction is a copy of one 4-bit nybble from a 12-bit source address to a 12-bit destination address. Arithmetic and control flow are side effects of writes to special addresses.

One ALU is mapped into the address space. Software writes the two operands, then writes an operation code to the mode location. That write makes the ALU compute. Software then reads the result and status nybbles. The program counter is also mapped, so writing its low nybble performs a jump.

The block sees the outside world through one nybble-wide memory port. The port has a combinational read path. Only addresses at or above the external base reach the port. Lower addresses are served inside the block.

Top module: `move_machine`

## Requirements
- R1: After reset the program counter is 0x020, and A, B, mode, result and status are 0. The first bus address is 0x020, with the write strobe low.
- R2: Each instruction takes 8 cycles:
  - six fetch cycles at consecutive addresses, most significant nybble first, three nybbles of source and then three of destination;
  - one cycle reading the source;
  - one cycle writing the destination, with the write strobe high for exactly that cycle.
- R3: A read from any address 0x000–0x00F returns the low nybble of that address.
- R4: A (0x010), B (0x011), mode (0x012), result (0x013) and status (0x014) read back the last value written to them.
- R5: A write of op to mode updates result and status from A, B and status carry, visible to the next instruction. Status bit 3 is V (signed overflow), bit 2 is N (result bit 3), bit 1 is Z (result zero) and bit 0 is C.
- R6: Mode codes for add and subtract:
  - 0 is A+B and 1 is A+B+C, with C the carry out;
  - 2 is A−B and 3 is A−B−C, with C set on borrow;
  - V reports two's complement overflow in all four.
- R7: Mode codes 4, 5 and 6 give AND, OR and XOR of A and B. Mode 7 gives NOT A. All four clear C and V.
- R8: Mode 8 is compare: status is set as for mode 2, and the result register is left unchanged.
- R9: Modes 9–F shift or rotate A by one place, with C taking the bit shifted out and V cleared:
  - 9 is shift left with zero fill;
  - A is shift right with zero fill;
  - B is arithmetic shift right;
  - C is rotate left and D is rotate right;
  - E is rotate left through C and F is rotate right through C.
- R10: Writes to 0x015 and 0x016 only stage the high and middle target nybbles; execution stays sequential. A write to 0x017 loads the whole PC at once, from the staged nybbles and the written nybble.
- R11: Reads of 0x015, 0x016 and 0x017 return the high, middle and low nybbles of the address of the following instruction.
- R12: A write below 0x020 never asserts the external write strobe. Writes to 0x000–0x00F and 0x018–0x01F have no effect, and reads of 0x018–0x01F return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Bus address for fetch, source read or destination write |
| mem_we_o | output | 1 | External write strobe |
| mem_wdata_o | output | 4 | Write data |
| mem_rdata_i | input | 4 | Combinational read data for mem_addr_o |

## Verification
After reset, the nth bus access (counting from zero) is visible n cycles later. For the first instruction, the bench samples the address, strobe and data on each falling edge of cycles 0 through 7. All other results are due as memory writes in the eighth cycle of the move that stores them. An ALU result is due in the instruction after the mode write. Programs end in a self-jump loop, and the bench reads memory only after a fixed run long enough to reach that loop. This means every stored nybble has settled before it is compared.

// File: rtl/move_cpu_pkg.sv
package move_cpu_pkg;
  localparam int AW = 12;
  localparam int DW = 4;

  localparam logic [AW-1:0] ADR_A    = 12'h010;
  localparam logic [AW-1:0] ADR_B    = 12'h011;
  localparam logic [AW-1:0] ADR_MODE = 12'h012;
  localparam logic [AW-1:0] ADR_RES  = 12'h013;
  localparam logic [AW-1:0] ADR_STAT = 12'h014;
  localparam logic [AW-1:0] ADR_PC2  = 12'h015;
  localparam logic [AW-1:0] ADR_PC1  = 12'h016;
  localparam logic [AW-1:0] ADR_PC0  = 12'h017;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;

  typedef enum logic [3:0] {
    OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_AND, OP_OR, OP_XOR, OP_NOT,
    OP_CMP, OP_SHL, OP_SHR, OP_SHRA, OP_ROL, OP_ROR, OP_ROLC, OP_RORC
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_S2, ST_S1, ST_S0, ST_D2, ST_D1, ST_D0, ST_RD, ST_WR
  } phase_e;
endpackage

// File: rtl/move_alu.sv
module move_alu
  import move_cpu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] flags_o,
  output logic          res_upd_o
);
  logic [DW:0]   sum;
  logic [DW-1:0] res;
  logic          c, v;

  always_comb begin
    sum       = '0;
    res       = a_i;
    c         = 1'b0;
    v         = 1'b0;
    res_upd_o = 1'b1;
    unique case (op_i)
      OP_ADD, OP_ADDC: begin
        sum = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, (op_i == OP_ADDC) & cin_i};
        res = sum[DW-1:0];
        c   = sum[DW];
        v   = (a_i[DW-1] == b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);
      end
      OP_SUB, OP_SUBB, OP_CMP: begin
        sum = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, (op_i == OP_SUBB) & cin_i};
        res = sum[DW-1:0];
        c   = sum[DW];
        v   = (a_i[DW-1] != b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);
        res_upd_o = (op_i != OP_CMP);
      end
      OP_AND:  res = a_i & b_i;
      OP_OR:   res = a_i | b_i;
      OP_XOR:  res = a_i ^ b_i;
      OP_NOT:  res = ~a_i;
      OP_SHL:  begin res = {a_i[DW-2:0], 1'b0};         c = a_i[DW-1]; end
      OP_SHR:  begin res = {1'b0, a_i[DW-1:1]};         c = a_i[0];    end
      OP_SHRA: begin res = {a_i[DW-1], a_i[DW-1:1]};    c = a_i[0];    end
      OP_ROL:  begin res = {a_i[DW-2:0], a_i[DW-1]};    c = a_i[DW-1]; end
      OP_ROR:  begin res = {a_i[0], a_i[DW-1:1]};       c = a_i[0];    end
      OP_ROLC: begin res = {a_i[DW-2:0], cin_i};        c = a_i[DW-1]; end
      OP_RORC: begin res = {cin_i, a_i[DW-1:1]};        c = a_i[0];    end
      default: res = a_i;
    endcase
  end

  assign res_o            = res;
  assign flags_o[FLG_C]   = c;
  assign flags_o[FLG_Z]   = (res == '0);
  assign flags_o[FLG_N]   = res[DW-1];
  assign flags_o[FLG_V]   = v;
endmodule

// File: rtl/move_ctrl.sv
module move_ctrl
  import move_cpu_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = 12'h020
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  input  logic          pc_load_i,
  input  logic [AW-1:0] pc_value_i,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] pc_o
);
  phase_e        phase_q;
  logic [AW-1:0] pc_q, src_q, dst_q;
  logic [DW-1:0] data_q;
  logic          fetch_src, fetch_dst;

  assign fetch_src = phase_q inside {ST_S2, ST_S1, ST_S0};
  assign fetch_dst = phase_q inside {ST_D2, ST_D1, ST_D0};

  always_comb begin
    if (phase_q == ST_RD)      addr_o = src_q;
    else if (phase_q == ST_WR) addr_o = dst_q;
    else                       addr_o = pc_q;
  end

  assign wr_en_o = (phase_q == ST_WR);
  assign wdata_o = data_q;
  assign pc_o    = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_S2;
      pc_q    <= RESET_PC;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
    end else begin
      phase_q <= (phase_q == ST_WR) ? ST_S2 : phase_e'(phase_q + 3'd1);
      // address nybbles shift in most significant first
      if (fetch_src) src_q <= {src_q[AW-DW-1:0], rdata_i};
      if (fetch_dst) dst_q <= {dst_q[AW-DW-1:0], rdata_i};
      if (phase_q == ST_RD) data_q <= rdata_i;
      if (fetch_src || fetch_dst) pc_q <= pc_q + 1'b1;
      else if (pc_load_i)         pc_q <= pc_value_i;
    end
  end

  assert_fetch_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q inside {ST_S1, ST_S0, ST_D2, ST_D1, ST_D0}) |-> addr_o == $past(addr_o) + 12'd1);

  assert_we_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  assert_pc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_RD || (phase_q == ST_WR && !pc_load_i)) |=> $stable(pc_q));
endmodule

// File: rtl/move_regmap.sv
module move_regmap
  import move_cpu_pkg::*;
#(
  parameter logic [AW-1:0] EXT_BASE = 12'h020
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] ext_rdata_i,
  input  logic [DW-1:0] alu_res_i,
  input  logic [DW-1:0] alu_flags_i,
  input  logic          alu_upd_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] mode_o,
  output logic          cin_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_value_o,
  output logic          ext_we_o
);
  logic [DW-1:0] a_q, b_q, mode_q, res_q, st_q, tgt2_q, tgt1_q;
  logic          internal;

  assign internal = (addr_i < EXT_BASE);

  always_comb begin
    if (addr_i[AW-1:DW] == '0) rdata_o = addr_i[DW-1:0];
    else if (addr_i == ADR_A)    rdata_o = a_q;
    else if (addr_i == ADR_B)    rdata_o = b_q;
    else if (addr_i == ADR_MODE) rdata_o = mode_q;
    else if (addr_i == ADR_RES)  rdata_o = res_q;
    else if (addr_i == ADR_STAT) rdata_o = st_q;
    else if (addr_i == ADR_PC2)  rdata_o = pc_i[3*DW-1:2*DW];
    else if (addr_i == ADR_PC1)  rdata_o = pc_i[2*DW-1:DW];
    else if (addr_i == ADR_PC0)  rdata_o = pc_i[DW-1:0];
    else if (internal)           rdata_o = '0;
    else                         rdata_o = ext_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; mode_q <= '0; res_q <= '0;
      st_q <= '0; tgt2_q <= '0; tgt1_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        ADR_A:    a_q    <= wdata_i;
        ADR_B:    b_q    <= wdata_i;
        ADR_RES:  res_q  <= wdata_i;
        ADR_STAT: st_q   <= wdata_i;
        ADR_PC2:  tgt2_q <= wdata_i;
        ADR_PC1:  tgt1_q <= wdata_i;
        ADR_MODE: begin
          mode_q <= wdata_i;
          st_q   <= alu_flags_i;
          if (alu_upd_i) res_q <= alu_res_i;
        end
        default: ;
      endcase
    end
  end

  assign a_o        = a_q;
  assign b_o        = b_q;
  assign mode_o     = mode_q;
  assign cin_o      = st_q[FLG_C];
  assign pc_load_o  = wr_en_i && (addr_i == ADR_PC0);
  assign pc_value_o = {tgt2_q, tgt1_q, wdata_i};
  assign ext_we_o   = wr_en_i && !internal;

  assert_res_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == ADR_RES || addr_i == ADR_MODE)) |=> $stable(res_q));

  assert_cmp_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_MODE && wdata_i == OP_CMP) |=> $stable(res_q));

  assert_stat_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == ADR_STAT || addr_i == ADR_MODE)) |=> $stable(st_q));
endmodule

// File: rtl/move_machine.sv
module move_machine
  import move_cpu_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = 12'h020,
  parameter logic [AW-1:0] EXT_BASE = 12'h020
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [11:0]   mem_addr_o,
  output logic          mem_we_o,
  output logic [3:0]    mem_wdata_o,
  input  logic [3:0]    mem_rdata_i
);
  logic [AW-1:0] bus_addr, pc, pc_value;
  logic [DW-1:0] rdata, wdata, a, b, mode, alu_res, alu_flags;
  logic          wr_en, pc_load, cin, alu_upd;

  move_ctrl #(.RESET_PC(RESET_PC)) u_ctrl (
    .clk_i, .rst_ni,
    .rdata_i(rdata), .pc_load_i(pc_load), .pc_value_i(pc_value),
    .addr_o(bus_addr), .wr_en_o(wr_en), .wdata_o(wdata), .pc_o(pc)
  );

  move_regmap #(.EXT_BASE(EXT_BASE)) u_regmap (
    .clk_i, .rst_ni,
    .addr_i(bus_addr), .wr_en_i(wr_en), .wdata_i(wdata), .pc_i(pc),
    .ext_rdata_i(mem_rdata_i), .alu_res_i(alu_res), .alu_flags_i(alu_flags),
    .alu_upd_i(alu_upd), .rdata_o(rdata), .a_o(a), .b_o(b), .mode_o(mode),
    .cin_o(cin), .pc_load_o(pc_load), .pc_value_o(pc_value), .ext_we_o(mem_we_o)
  );

  // ALU evaluates the nybble being written, which is the new mode on a mode write
  move_alu u_alu (
    .a_i(a), .b_i(b), .cin_i(cin), .op_i(alu_op_e'(wdata)),
    .res_o(alu_res), .flags_o(alu_flags), .res_upd_o(alu_upd)
  );

  assign mem_addr_o  = bus_addr;
  assign mem_wdata_o = wdata;

  assert_ext_we_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o >= EXT_BASE);

  assert_mode_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && bus_addr == ADR_MODE) |=> mode == $past(wdata));
endmodule

// File: tb/move_machine_bench.sv
`timescale 1ns/1ps
module move_machine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_wdata, mem_rdata;
  logic [3:0]  mem [4096];

  int n_tests = 0, n_fail = 0;
  logic [11:0] pp, dp;
  logic [11:0] ex_a [64];
  logic [3:0]  ex_v [64];
  string       ex_t [64];
  int          n_ex;

  always #5 clk = ~clk;

  move_machine u_move_machine (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  // R12: no external strobe for internal addresses
  always @(negedge clk)
    if (rst_n && mem_we && mem_addr < 12'h020) begin
      n_fail++;
      $display("FAIL R12 ext write at %h (expected none)", mem_addr);
    end

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] k(logic [3:0] n);
    return {8'h00, n};
  endfunction

  task automatic emit(logic [11:0] src, logic [11:0] dst);
    for (int i = 0; i < 3; i++) begin
      mem[pp + 12'(i)]     = src[11-4*i -: 4];
      mem[pp + 12'(i + 3)] = dst[11-4*i -: 4];
    end
    pp = pp + 12'd6;
  endtask

  task automatic want(string tag, logic [3:0] v);
    ex_a[n_ex] = dp; ex_v[n_ex] = v; ex_t[n_ex] = tag;
    n_ex++;
  endtask

  task automatic store(logic [11:0] src, string tag, logic [3:0] v);
    emit(src, dp); want(tag, v); dp = dp + 12'd1;
  endtask

  task automatic alu_case(string tag, logic [3:0] pre, logic [3:0] a, logic [3:0] b,
                          logic [3:0] op, logic [3:0] er, logic [3:0] es);
    emit(k(pre), 12'h014);
    emit(k(a), 12'h010);
    emit(k(b), 12'h011);
    emit(k(op), 12'h012);
    store(12'h013, {tag, " result"}, er);
    store(12'h014, {tag, " status"}, es);
  endtask

  task automatic begin_test();
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 4'h0;
    for (int i = 12'h300; i < 12'h340; i++) mem[i] = 4'hF;
    pp = 12'h020; dp = 12'h300; n_ex = 0;
    @(negedge clk);
  endtask

  task automatic halt();
    logic [11:0] t;
    t = pp + 12'd12;
    emit(k(t[11:8]), 12'h015);
    emit(k(t[7:4]), 12'h016);
    emit(k(t[3:0]), 12'h017);
  endtask

  task automatic run_and_check();
    halt();
    @(negedge clk); rst_n = 1'b1;
    repeat (760) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < n_ex; i++) chk(ex_t[i], {8'h0, mem[ex_a[i]]}, {8'h0, ex_v[i]});
  endtask

  task automatic t_trace();
    logic [11:0] ea;
    begin_test();
    emit(k(4'h5), 12'h300);
    halt();
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 reset address", mem_addr, 12'h020);
    chk("R1 reset strobe", {11'h0, mem_we}, 12'h0);
    for (int i = 1; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      ea = (i < 6) ? 12'h020 + 12'(i) : (i == 6) ? 12'h005 : 12'h300;
      chk($sformatf("R2 bus address cycle %0d", i), mem_addr, ea);
      chk($sformatf("R2 strobe cycle %0d", i), {11'h0, mem_we}, {11'h0, i == 7});
    end
    chk("R2 write data", {8'h0, mem_wdata}, 12'h005);
    @(posedge clk); @(negedge clk);
    chk("R3 constant stored", {8'h0, mem[12'h300]}, 12'h005);
  endtask

  task automatic t_regs();
    begin_test();
    store(12'h010, "R1 A reset", 4'h0);
    store(12'h011, "R1 B reset", 4'h0);
    store(12'h012, "R1 mode reset", 4'h0);
    store(12'h013, "R1 result reset", 4'h0);
    store(12'h014, "R1 status reset", 4'h0);
    emit(k(4'h7), 12'h010); store(12'h010, "R4 A", 4'h7);
    emit(k(4'h9), 12'h011); store(12'h011, "R4 B", 4'h9);
    emit(k(4'hC), 12'h013); store(12'h013, "R4 result", 4'hC);
    emit(k(4'hA), 12'h014); store(12'h014, "R4 status", 4'hA);
    emit(k(4'h4), 12'h012); store(12'h012, "R4 mode", 4'h4);
    run_and_check();
  endtask

  task automatic t_arith();
    begin_test();
    alu_case("R6 add 9+8",        4'h0, 4'h9, 4'h8, 4'h0, 4'h1, 4'h9);
    alu_case("R6 addc 9+8+1",     4'h1, 4'h9, 4'h8, 4'h1, 4'h2, 4'h9);
    alu_case("R6 sub 3-5",        4'h0, 4'h3, 4'h5, 4'h2, 4'hE, 4'h5);
    alu_case("R6 subb 7-7-1",     4'h1, 4'h7, 4'h7, 4'h3, 4'hF, 4'h5);
    alu_case("R5 subb 7-7-0 zero",4'h0, 4'h7, 4'h7, 4'h3, 4'h0, 4'h2);
    alu_case("R6 add 7+1 ovf",    4'h0, 4'h7, 4'h1, 4'h0, 4'h8, 4'hC);
    run_and_check();
  endtask

  task automatic t_logic();
    begin_test();
    alu_case("R7 and",      4'hF, 4'hC, 4'hA, 4'h4, 4'h8, 4'h4);
    alu_case("R7 or",       4'hF, 4'hC, 4'hA, 4'h5, 4'hE, 4'h4);
    alu_case("R7 xor",      4'hF, 4'hC, 4'hA, 4'h6, 4'h6, 4'h0);
    alu_case("R7 not",      4'hF, 4'hC, 4'hA, 4'h7, 4'h3, 4'h0);
    alu_case("R7 and zero", 4'hF, 4'hC, 4'h3, 4'h4, 4'h0, 4'h2);
    run_and_check();
  endtask

  task automatic t_cmp();
    begin_test();
    alu_case("R6 add 1+1",   4'h0, 4'h1, 4'h1, 4'h0, 4'h2, 4'h0);
    alu_case("R8 cmp equal", 4'h0, 4'h4, 4'h4, 4'h8, 4'h2, 4'h2);
    alu_case("R8 cmp less",  4'h0, 4'h2, 4'h5, 4'h8, 4'h2, 4'h5);
    run_and_check();
  endtask

  task automatic t_shift();
    begin_test();
    alu_case("R9 shl",       4'h0, 4'h9, 4'h0, 4'h9, 4'h2, 4'h1);
    alu_case("R9 shr",       4'h0, 4'h9, 4'h0, 4'hA, 4'h4, 4'h1);
    alu_case("R9 shra",      4'h0, 4'h9, 4'h0, 4'hB, 4'hC, 4'h5);
    alu_case("R9 rol",       4'h0, 4'h9, 4'h0, 4'hC, 4'h3, 4'h1);
    alu_case("R9 ror",       4'h0, 4'h9, 4'h0, 4'hD, 4'hC, 4'h5);
    alu_case("R9 rolc c0",   4'h0, 4'h9, 4'h0, 4'hE, 4'h2, 4'h1);
    alu_case("R9 rolc c1",   4'h1, 4'h9, 4'h0, 4'hE, 4'h3, 4'h1);
    alu_case("R9 rorc c1",   4'h1, 4'h9, 4'h0, 4'hF, 4'hC, 4'h5);
    alu_case("R9 rorc c0",   4'h0, 4'h9, 4'h0, 4'hF, 4'h4, 4'h1);
    run_and_check();
  endtask

  task automatic t_jump();
    begin_test();
    mem[12'h300] = 4'h0; mem[12'h303] = 4'h0; mem[12'h304] = 4'h0;
    emit(k(4'h3), 12'h015);        // 0x020 stage only
    emit(k(4'h6), 12'h300);        // 0x026 must still run
    emit(12'h017, 12'h301);        // 0x02C next pc 0x032
    emit(12'h016, 12'h302);        // 0x032 next pc 0x038
    emit(k(4'h0), 12'h015);        // 0x038
    emit(k(4'h8), 12'h016);        // 0x03E
    emit(k(4'h0), 12'h017);        // 0x044 jump to 0x080
    emit(k(4'hE), 12'h303);        // 0x04A skipped
    pp = 12'h080;
    emit(k(4'h9), 12'h304);
    halt();
    @(negedge clk); rst_n = 1'b1;
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk("R10 staging write keeps sequence", {8'h0, mem[12'h300]}, 12'h006);
    chk("R11 pc low nybble", {8'h0, mem[12'h301]}, 12'h002);
    chk("R11 pc middle nybble", {8'h0, mem[12'h302]}, 12'h003);
    chk("R10 jumped-over move skipped", {8'h0, mem[12'h303]}, 12'h000);
    chk("R10 jump target executed", {8'h0, mem[12'h304]}, 12'h009);
  endtask

  task automatic t_ignore();
    begin_test();
    store(k(4'h0), "R3 constant 0", 4'h0);
    store(k(4'hA), "R3 constant A", 4'hA);
    emit(k(4'hF), 12'h005);
    store(12'h005, "R12 constant unchanged", 4'h5);
    emit(k(4'h9), 12'h018);
    store(12'h018, "R12 unused reads zero", 4'h0);
    store(12'h01F, "R12 unused top reads zero", 4'h0);
    run_and_check();
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired (expected completion)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_trace();
    t_regs();
    t_arith();
    t_logic();
    t_cmp();
    t_shift();
    t_jump();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule